// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block governs how a CAN node climbs back out of the bus-off state. When the error logic reports bus-off, the block raises the node's initialization bit and holds it. Bus activity stops. The block then waits for the host CPU to clear that bit. After that it watches the received bit stream, one sampled bit per bit-time strobe, and counts runs of 11 consecutive recessive (high) bits. Each such run stands for one period of bus idle.

Each completed run writes a progress code into the last-error-code status field, so software can follow the recovery and tell whether the bus is stuck dominant. Once the 129th run completes, the block does two things. It emits a one-cycle pulse that clears the external error counters, and it emits a one-cycle pulse that announces the node has recovered. The host cannot shorten the wait: writes to the initialization bit are ignored while counting is under way.

The sampled bit is a plain strobe-qualified input, not a handshaked stream. The block applies no back-pressure: every strobed bit is consumed in the cycle it is presented.

Top module: `busoff_recovery`

## Requirements
- R1: After reset, `init_o` is 1, every pulse output is 0 and `lec_code_o` is 3'b000. While no recovery is in progress, a host write (`init_wr_i` with `init_wdata_i`) sets `init_o` to the written value from the next cycle.
- R2: While no recovery is in progress, a `bus_off_i` pulse sets `init_o` to 1 from the next cycle and starts the wait. A `bus_off_i` pulse during a recovery already in progress is ignored and does not restart the count.
- R3: While `init_o` stays 1 after bus-off, strobed recessive bits are not counted and produce no `lec_wr_o` pulse.
- R4: Once the host has cleared `init_o`, each 11th consecutive strobed recessive bit produces a one-cycle `lec_wr_o` pulse in the cycle after that strobe, and `lec_code_o` holds 3'b101 from then on.
- R5: After a completed run, the run count restarts at zero, so the next pulse needs 11 new recessive bits.
- R6: A strobed dominant (0) bit clears the current run but keeps the number of completed runs.
- R7: When the 129th run completes, `cnt_reset_o` and `recovered_o` are high together for exactly one cycle, in the same cycle as the 129th `lec_wr_o` pulse. The block then returns to the no-recovery state, and further recessive bits produce no pulses.
- R8: During counting, host writes to the initialization bit are ignored: `init_o` stays 0 and the number of runs still needed is unchanged.
- R9: `rx_i` is sampled only in cycles where `bit_stb_i` is 1. A recessive level without a strobe counts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_off_i | input | 1 | Pulse from error logic: node entered bus-off |
| init_wr_i | input | 1 | Host write strobe for the initialization bit |
| init_wdata_i | input | 1 | Value written to the initialization bit |
| bit_stb_i | input | 1 | One-cycle strobe per bit time |
| rx_i | input | 1 | Sampled bus level, 1 = recessive |
| init_o | output | 1 | Current initialization bit |
| lec_wr_o | output | 1 | One-cycle write pulse for the last-error-code field |
| lec_code_o | output | 3 | Last code written to the status field |
| cnt_reset_o | output | 1 | One-cycle pulse clearing the error counters |
| recovered_o | output | 1 | One-cycle pulse: recovery complete |

## Verification
A corrupted run counter shows up at the ports as a `lec_wr_o` pulse that comes too early or too late, relative to the strobe count since the last pulse or the last dominant bit. A sweep of run lengths around 11 exposes it within one run. A corrupted sequence count shows up only at the end, as a `recovered_o` pulse that does not land on exactly the 129th progress pulse. The bench therefore counts every pulse over full recoveries, including one that carries a dominant bit, an ignored host write and an ignored bus-off. A stuck state shows up at once in `init_o`, or as progress pulses that arrive in the wait or after recovery.

// File: rtl/busoff_rec_pkg.sv
package busoff_rec_pkg;

  typedef enum logic [1:0] {
    RS_IDLE      = 2'd0,
    RS_WAIT_INIT = 2'd1,
    RS_COUNT     = 2'd2,
    RS_DONE      = 2'd3
  } rec_state_e;

  localparam logic [2:0] LEC_NONE      = 3'b000;
  localparam logic [2:0] LEC_IDLE_SEEN = 3'b101;

endpackage

// File: rtl/rec_run_counter.sv
module rec_run_counter #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic bit_stb,
  input  logic rx,
  output logic run_done
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!enable) begin
      run_q <= '0;
    end else if (bit_stb) begin
      if (!rx || run_q == RUN_LAST) begin
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign run_done = enable && bit_stb && rx && (run_q == RUN_LAST);

endmodule

// File: rtl/rec_seq_counter.sv
module rec_seq_counter #(
  parameter int SEQ_NEED = 129
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic inc,
  output logic last_run
);
  localparam int SEQ_W = $clog2(SEQ_NEED + 1);
  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(SEQ_NEED - 1);

  logic [SEQ_W-1:0] seq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= '0;
    end else if (!enable) begin
      seq_q <= '0;
    end else if (inc) begin
      seq_q <= seq_q + 1'b1;
    end
  end

  assign last_run = inc && (seq_q == SEQ_LAST);

endmodule

// File: rtl/rec_ctrl_fsm.sv
module rec_ctrl_fsm
  import busoff_rec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_off_i,
  input  logic       init_wr_i,
  input  logic       init_wdata_i,
  input  logic       run_done,
  input  logic       last_run,
  output rec_state_e state_q,
  output logic       count_en,
  output logic       init_o,
  output logic       lec_wr_o,
  output logic [2:0] lec_code_o,
  output logic       cnt_reset_o,
  output logic       recovered_o
);
  rec_state_e state_d;
  logic       init_q;
  logic       lec_wr_q;
  logic [2:0] lec_code_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_IDLE:      if (bus_off_i) state_d = RS_WAIT_INIT;
      RS_WAIT_INIT: if (!init_q)   state_d = RS_COUNT;
      RS_COUNT:     if (last_run)  state_d = RS_DONE;
      RS_DONE:                     state_d = RS_IDLE;
      default:                     state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RS_IDLE;
      init_q     <= 1'b1;
      lec_wr_q   <= 1'b0;
      lec_code_q <= LEC_NONE;
    end else begin
      state_q  <= state_d;
      lec_wr_q <= run_done;
      if (run_done) lec_code_q <= LEC_IDLE_SEEN;
      case (state_q)
        RS_IDLE: begin
          if (bus_off_i)      init_q <= 1'b1;
          else if (init_wr_i) init_q <= init_wdata_i;
        end
        RS_WAIT_INIT: begin
          if (init_wr_i) init_q <= init_wdata_i;
        end
        default: init_q <= init_q;
      endcase
    end
  end

  assign count_en    = (state_q == RS_COUNT);
  assign init_o      = init_q;
  assign lec_wr_o    = lec_wr_q;
  assign lec_code_o  = lec_code_q;
  assign cnt_reset_o = (state_q == RS_DONE);
  assign recovered_o = (state_q == RS_DONE);

endmodule

// File: rtl/busoff_recovery.sv
module busoff_recovery
  import busoff_rec_pkg::*;
#(
  parameter int RUN_LEN  = 11,
  parameter int SEQ_NEED = 129
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_off_i,
  input  logic       init_wr_i,
  input  logic       init_wdata_i,
  input  logic       bit_stb_i,
  input  logic       rx_i,
  output logic       init_o,
  output logic       lec_wr_o,
  output logic [2:0] lec_code_o,
  output logic       cnt_reset_o,
  output logic       recovered_o
);
  rec_state_e state_w;
  logic       count_en;
  logic       run_done;
  logic       last_run;

  rec_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (count_en),
    .bit_stb  (bit_stb_i),
    .rx       (rx_i),
    .run_done (run_done)
  );

  rec_seq_counter #(.SEQ_NEED(SEQ_NEED)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (count_en),
    .inc      (run_done),
    .last_run (last_run)
  );

  rec_ctrl_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_off_i    (bus_off_i),
    .init_wr_i    (init_wr_i),
    .init_wdata_i (init_wdata_i),
    .run_done     (run_done),
    .last_run     (last_run),
    .state_q      (state_w),
    .count_en     (count_en),
    .init_o       (init_o),
    .lec_wr_o     (lec_wr_o),
    .lec_code_o   (lec_code_o),
    .cnt_reset_o  (cnt_reset_o),
    .recovered_o  (recovered_o)
  );

endmodule

// File: rtl/busoff_recovery_chk.sv
module busoff_recovery_chk
  import busoff_rec_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_off_i,
  input logic       bit_stb_i,
  input logic       rx_i,
  input logic       init_o,
  input logic       lec_wr_o,
  input logic       cnt_reset_o,
  input logic       recovered_o,
  input rec_state_e state_q
);

  assert_busoff_sets_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_IDLE && bus_off_i) |=> (init_o && state_q == RS_WAIT_INIT));

  assert_no_lec_while_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_o |-> !lec_wr_o);

  assert_lec_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lec_wr_o |-> ($past(bit_stb_i) && $past(rx_i)));

  assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    recovered_o |=> !recovered_o);

  assert_done_with_last_lec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    recovered_o |-> (lec_wr_o && cnt_reset_o));

  assert_init_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_COUNT) |-> !init_o);

endmodule

bind busoff_recovery busoff_recovery_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_off_i   (bus_off_i),
  .bit_stb_i   (bit_stb_i),
  .rx_i        (rx_i),
  .init_o      (init_o),
  .lec_wr_o    (lec_wr_o),
  .cnt_reset_o (cnt_reset_o),
  .recovered_o (recovered_o),
  .state_q     (state_w)
);

// File: tb/busoff_recovery_tb.sv
module busoff_recovery_tb;
  localparam int RUN = 11;
  localparam int SEQ = 129;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_off_i = 1'b0, init_wr_i = 1'b0, init_wdata_i = 1'b0;
  logic bit_stb_i = 1'b0, rx_i = 1'b0;
  logic init_o, lec_wr_o, cnt_reset_o, recovered_o;
  logic [2:0] lec_code_o;

  int tests = 0, fails = 0;
  int lec_cnt = 0, rec_cnt = 0, crst_cnt = 0, misalign = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  busoff_recovery u_dut (
    .clk(clk), .rst_n(rst_n), .bus_off_i(bus_off_i), .init_wr_i(init_wr_i),
    .init_wdata_i(init_wdata_i), .bit_stb_i(bit_stb_i), .rx_i(rx_i),
    .init_o(init_o), .lec_wr_o(lec_wr_o), .lec_code_o(lec_code_o),
    .cnt_reset_o(cnt_reset_o), .recovered_o(recovered_o)
  );

  always @(negedge clk) if (rst_n) begin
    if (lec_wr_o) lec_cnt++;
    if (recovered_o) rec_cnt++;
    if (cnt_reset_o) crst_cnt++;
    if ((recovered_o != cnt_reset_o) || (recovered_o && !lec_wr_o)) misalign++;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_counts();
    lec_cnt = 0; rec_cnt = 0; crst_cnt = 0; misalign = 0;
  endtask

  task automatic send_bits(input int n, input logic b);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_stb_i = 1'b1; rx_i = b;
      @(negedge clk); bit_stb_i = 1'b0; rx_i = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic host_write(input logic v);
    @(negedge clk); init_wr_i = 1'b1; init_wdata_i = v;
    @(negedge clk); init_wr_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_busoff();
    @(negedge clk); bus_off_i = 1'b1;
    @(negedge clk); bus_off_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset init", init_o, 1);
    chk("R1 reset lec_code", lec_code_o, 0);
    chk("R1 reset recovered", recovered_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: host write in idle takes effect
    host_write(1'b0);
    chk("R1 idle write 0", init_o, 0);
    clr_counts();
    send_bits(30, 1'b1);
    chk("R1 idle bits no lec", lec_cnt, 0);
    // R2: bus-off sets init
    pulse_busoff();
    chk("R2 busoff sets init", init_o, 1);
    // R3: no counting while init held
    clr_counts();
    send_bits(40, 1'b1);
    chk("R3 waiting no lec", lec_cnt, 0);
    host_write(1'b1);
    send_bits(15, 1'b1);
    chk("R3 write 1 keeps waiting", lec_cnt + 10 * init_o, 10);
    host_write(1'b0);
    @(negedge clk);
    // R5/R4: sweep run lengths from 1 to 2*RUN+1, each closed by a dominant bit
    for (int n = 1; n <= 2 * RUN + 1; n++) begin
      clr_counts();
      send_bits(n, 1'b1);
      send_bits(1, 1'b0);
      chk($sformatf("R5 run of %0d", n), lec_cnt, n / RUN);
    end
    // completed so far: sum over n of n/RUN
    begin
      int done_runs = 0;
      for (int n = 1; n <= 2 * RUN + 1; n++) done_runs += n / RUN;
      chk("R4 lec code after runs", lec_code_o, 5);
      // R6: dominant in middle keeps completed count
      clr_counts();
      send_bits(RUN - 1, 1'b1); send_bits(1, 1'b0); send_bits(RUN - 1, 1'b1);
      chk("R6 dominant breaks run", lec_cnt, 0);
      send_bits(1, 1'b1);
      chk("R6 fresh run completes", lec_cnt, 1);
      done_runs += 1;
      // R9: recessive without strobe
      rx_i = 1'b1;
      repeat (3 * RUN) @(negedge clk);
      chk("R9 no strobe no count", lec_cnt, 1);
      // R8: host write ignored during counting
      host_write(1'b1);
      chk("R8 init stays 0", init_o, 0);
      // R2: bus-off during counting ignored
      pulse_busoff();
      chk("R2 busoff ignored", init_o, 0);
      // finish: one bit short of remaining
      clr_counts();
      send_bits((SEQ - done_runs) * RUN - 1, 1'b1);
      chk("R8 not recovered early", rec_cnt, 0);
      chk("R8 runs before last", lec_cnt, SEQ - done_runs - 1);
      send_bits(1, 1'b1);
      chk("R7 recovered once", rec_cnt, 1);
      chk("R7 counter reset once", crst_cnt, 1);
      chk("R7 aligned with last lec", misalign, 0);
      chk("R7 init after recovery", init_o, 0);
      clr_counts();
      send_bits(3 * RUN, 1'b1);
      chk("R7 no lec after recovery", lec_cnt + rec_cnt, 0);
    end
    // second full recovery, uninterrupted
    pulse_busoff();
    host_write(1'b0);
    clr_counts();
    send_bits(SEQ * RUN, 1'b1);
    chk("R4 full lec count", lec_cnt, SEQ);
    chk("R7 second recovery", rec_cnt, 1);
    chk("R7 second aligned", misalign, 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule